// File: doc/BRIEF.md
# Loss-of-Signal Detector with Hysteresis

The block watches a stream of digitised input-amplitude samples and raises a loss-of-signal flag when the signal has gone too weak. A programmable trip level sets where the flag raises. Once raised, the flag clears only after the amplitude has climbed to double the trip level. This gives a fixed 6 dB hysteresis band, which keeps the flag from chattering when the level sits close to the trip point.

Neither transition happens on a single sample. A qualifier commits a change only after the triggering condition has held for `QUAL` consecutive valid samples. The default of 25 samples matches about 500 ns at a 50 MHz sample clock. The amplitude input is the absolute signal level, so any slicing offset applied elsewhere in the data path never reaches this decision. A polarity bit selects whether the output pin is active high (the default) or active low.

Top module: `los_detector`

## Requirements
- R1: Out of reset the detector is in the lost state. `los_o` reads 1 when `inv_pol_i` is 0 and reads 0 when `inv_pol_i` is 1.
- R2: In the clear state, `QUAL` consecutive valid samples with `amp_i < thresh_i` move the detector to the lost state, at the clock edge that takes the last of those samples.
- R3: In the lost state, `QUAL` consecutive valid samples with `amp_i >= 2*thresh_i` move the detector to the clear state. Amplitudes at or above `thresh_i` but below `2*thresh_i` keep it lost.
- R4: When `2*thresh_i` does not fit in `AMP_W` bits, the release level saturates to all ones (4095 for `AMP_W`=12). Only that amplitude then releases the flag.
- R5: A valid sample that does not meet the pending condition restarts the qualification count from zero.
- R6: Samples with `valid_i` low are ignored. They neither advance nor clear the qualification count, and they never change the state.
- R7: `inv_pol_i`=1 inverts `los_o` in the same cycle, combinationally, and leaves the detector state untouched.
- R8: Comparisons are exact at the boundaries. `amp_i == thresh_i` is not a loss, and `amp_i == 2*thresh_i - 1` is not a release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Qualifies `amp_i` as a new sample |
| amp_i | input | AMP_W | Absolute input amplitude |
| thresh_i | input | AMP_W | Programmed loss trip level |
| inv_pol_i | input | 1 | 1 selects active-low output |
| los_o | output | 1 | Loss-of-signal flag after polarity |

## Verification
The state register is the only register between the sample inputs and `los_o`. A transition is therefore visible one edge after the `QUAL`-th qualifying sample, and the bench checks at the falling edge that follows it. Each transition is also checked after `QUAL`-1 samples, to show it has not happened one sample early. A change of `inv_pol_i` is combinational, so it is checked a fraction of a cycle after the change, with no clock edge in between. Gaps with `valid_i` low and breaking samples are placed inside the qualification windows. This proves that the count holds across a gap and restarts after a break.

// File: rtl/los_pkg.sv
package los_pkg;
  typedef enum logic {
    LOS_CLEAR = 1'b0,
    LOS_LOST  = 1'b1
  } los_state_e;
endpackage

// File: rtl/los_release_level.sv
// Release level = 2 * threshold, saturating at all ones.
module los_release_level #(
  parameter int AMP_W = 12
) (
  input  logic [AMP_W-1:0] thresh_i,
  output logic [AMP_W-1:0] rel_o
);
  logic [AMP_W:0] dbl;
  assign dbl   = {thresh_i, 1'b0};
  assign rel_o = dbl[AMP_W] ? {AMP_W{1'b1}} : dbl[AMP_W-1:0];
endmodule

// File: rtl/los_cond.sv
// Flags a sample that argues for leaving the current state.
module los_cond
  import los_pkg::*;
#(
  parameter int AMP_W = 12
) (
  input  los_state_e       state_i,
  input  logic [AMP_W-1:0] amp_i,
  input  logic [AMP_W-1:0] thresh_i,
  input  logic [AMP_W-1:0] rel_i,
  output logic             cond_o
);
  always_comb begin
    if (state_i == LOS_CLEAR) cond_o = (amp_i < thresh_i);
    else                      cond_o = (amp_i >= rel_i);
  end
endmodule

// File: rtl/los_qualifier.sv
// Counts consecutive qualifying samples; fires on the QUAL-th.
module los_qualifier #(
  parameter int QUAL = 25,
  localparam int CW  = (QUAL < 2) ? 1 : $clog2(QUAL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          cond_i,
  output logic          fire_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LAST = CW'(QUAL - 1);

  logic [CW-1:0] cnt_q;

  assign fire_o = valid_i && cond_i && (cnt_q == LAST);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (valid_i) begin
      if (cond_i && !fire_o) cnt_q <= cnt_q + 1'b1;
      else                   cnt_q <= '0;
    end
  end
endmodule

// File: rtl/los_detector.sv
module los_detector
  import los_pkg::*;
#(
  parameter int AMP_W = 12,
  parameter int QUAL  = 25,
  localparam int CW   = (QUAL < 2) ? 1 : $clog2(QUAL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [AMP_W-1:0] amp_i,
  input  logic [AMP_W-1:0] thresh_i,
  input  logic             inv_pol_i,
  output logic             los_o
);
  los_state_e       state_q;
  logic [AMP_W-1:0] rel_lvl;
  logic             cond;
  logic             fire;
  logic [CW-1:0]    cnt_q;

  los_release_level #(.AMP_W(AMP_W)) u_rel (
    .thresh_i (thresh_i),
    .rel_o    (rel_lvl)
  );

  los_cond #(.AMP_W(AMP_W)) u_cond (
    .state_i  (state_q),
    .amp_i    (amp_i),
    .thresh_i (thresh_i),
    .rel_i    (rel_lvl),
    .cond_o   (cond)
  );

  los_qualifier #(.QUAL(QUAL)) u_qual (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .cond_i  (cond),
    .fire_o  (fire),
    .cnt_o   (cnt_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   state_q <= LOS_LOST;
    else if (fire) state_q <= (state_q == LOS_LOST) ? LOS_CLEAR : LOS_LOST;
  end

  assign los_o = (state_q == LOS_LOST) ^ inv_pol_i;
endmodule

// File: rtl/los_detector_chk.sv
module los_detector_chk #(
  parameter int AMP_W = 12,
  parameter int QUAL  = 25,
  localparam int CW   = (QUAL < 2) ? 1 : $clog2(QUAL)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [AMP_W-1:0] amp_i,
  input logic [AMP_W-1:0] thresh_i,
  input logic             state_i,
  input logic [AMP_W-1:0] rel_i,
  input logic [CW-1:0]    cnt_i
);
  // R2: entering the lost state needs a valid sample below the trip level
  a_r2_assert_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_i) |-> $past(valid_i && (amp_i < thresh_i)));

  // R3: leaving the lost state needs a valid sample at or above the release level
  a_r3_release_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(state_i) |-> $past(valid_i && (amp_i >= rel_i)));

  // R4: the release level is never below the trip level, even when it saturates
  a_r4_rel_not_below: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_i >= thresh_i);

  // R6: a cycle without a valid sample changes neither state nor count
  a_r6_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(state_i) && $stable(cnt_i)));

  // R5: the qualification count stays inside its window
  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_i) < QUAL);
endmodule

bind los_detector los_detector_chk #(.AMP_W(AMP_W), .QUAL(QUAL)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .amp_i    (amp_i),
  .thresh_i (thresh_i),
  .state_i  (state_q),
  .rel_i    (rel_lvl),
  .cnt_i    (cnt_q)
);

// File: tb/los_detector_bench.sv
module los_detector_bench;
  localparam int AMP_W = 12;
  localparam int QUAL  = 25;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             valid_i = 1'b0;
  logic [AMP_W-1:0] amp_i = '0;
  logic [AMP_W-1:0] thresh_i = 12'd100;
  logic             inv_pol_i = 1'b0;
  logic             los_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  los_detector #(.AMP_W(AMP_W), .QUAL(QUAL)) u_los_detector (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .amp_i     (amp_i),
    .thresh_i  (thresh_i),
    .inv_pol_i (inv_pol_i),
    .los_o     (los_o)
  );

  task automatic check(input string req, input logic exp);
    checks++;
    if (los_o !== exp) begin
      errors++;
      $display("FAIL %s: los_o actual %b expected %b", req, los_o, exp);
    end
  endtask

  // n valid samples of value a, then valid drops at the next falling edge
  task automatic feed(input int a, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b1;
      amp_i   = AMP_W'(a);
    end
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 reset active high", 1'b1);
    inv_pol_i = 1'b1; #1;
    check("R1 reset active low", 1'b0);
    inv_pol_i = 1'b0; #1;
  endtask

  task automatic t_release;
    thresh_i = 12'd100;
    feed(199, 30);
    check("R8 2x-1 does not release", 1'b1);
    feed(150, 30);
    check("R3 inside band stays lost", 1'b1);
    feed(200, QUAL - 1);
    check("R3 one sample short", 1'b1);
    feed(200, 1);
    check("R3 release at 2x after gap (R6)", 1'b0);
  endtask

  task automatic t_assert;
    feed(100, 40);
    check("R8 equal to trip is not loss", 1'b0);
    feed(99, QUAL - 1);
    check("R2 one sample short", 1'b0);
    feed(50, 1);
    check("R2 loss after QUAL samples", 1'b1);
  endtask

  task automatic t_restart;
    feed(200, QUAL);
    check("R3 release full window", 1'b0);
    feed(99, QUAL - 1);
    feed(100, 1);
    feed(99, QUAL - 1);
    check("R5 break restarts count", 1'b0);
    feed(99, 1);
    check("R5 full window after restart", 1'b1);
  endtask

  task automatic t_valid;
    feed(300, 20);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0;
      amp_i   = '0;
    end
    check("R6 invalid samples ignored", 1'b1);
    feed(300, QUAL - 20);
    check("R6 count held across gap", 1'b0);
  endtask

  task automatic t_sat;
    thresh_i = 12'd3000;
    feed(100, QUAL);
    check("R2 loss with high trip", 1'b1);
    feed(4094, 40);
    check("R4 below saturated level holds", 1'b1);
    feed(4095, QUAL);
    check("R4 saturated level releases", 1'b0);
  endtask

  task automatic t_pol;
    inv_pol_i = 1'b1; #1;
    check("R7 inverted clear", 1'b1);
    feed(10, QUAL);
    check("R7 inverted lost", 1'b0);
    inv_pol_i = 1'b0; #1;
    check("R7 back to active high", 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_release();
    t_assert();
    t_restart();
    t_valid();
    t_sat();
    t_pol();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule